// File: doc/BRIEF.md
# Alphabet UART Source

This block is a free-running serial character generator that sits on the terminal side of an asynchronous serial link with modem control lines. Once reset is released it sends the letters of the alphabet, one per frame, starting from a base character chosen at compile time. After the twenty-sixth letter it starts again from the base character. The line rate is a fixed division of the system clock.

The block raises its two terminal-owned control outputs as soon as it runs. It honours the clear-to-send input from the far side: a new character is started only while that input is high, and a character already on the wire always finishes. The other equipment-owned inputs (receive data, carrier, equipment ready, ring) are accepted but have no effect. Two copies, one with an uppercase base and one with a lowercase base, differ only in that parameter.

Top module: `alpha_uart_dte`

## Requirements
- R1: While the active-low asynchronous reset is asserted, the serial output is high and both control outputs are low.
- R2: Each character is sent as one low start bit, eight data bits with the least significant bit first, and one high stop bit; the line is high whenever no frame is in progress.
- R3: Every bit of a frame, including the first bit after an idle period, lasts exactly CLK_HZ / BAUD clock cycles.
- R4: The first character sent after reset is FIRST_CHAR (default 8'h41, 'A').
- R5: Each later character is the previous character plus one.
- R6: After the character FIRST_CHAR + 25 has been sent, the next character is FIRST_CHAR again.
- R7: No new frame starts while the clear-to-send input is low; the line stays high until it returns high.
- R8: A frame that has started completes with correct data and stop bit even if clear-to-send falls during it.
- R9: The receive-data, carrier, equipment-ready and ring inputs have no effect on the serial output.
- R10: From the first clock edge after reset release, both control outputs are high and remain high.
- R11: An instance with FIRST_CHAR = 8'h61 ('a') sends the lowercase alphabet with the same framing, timing and wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_to_send_i | input | 1 | Far side permits a new frame when high |
| ser_in_i | input | 1 | Receive data from the far side (ignored) |
| carrier_i | input | 1 | Carrier indication (ignored) |
| peer_ready_i | input | 1 | Equipment ready indication (ignored) |
| ring_i | input | 1 | Ring indication (ignored) |
| ser_out_o | output | 1 | Serial transmit line, idles high |
| term_ready_o | output | 1 | Terminal ready, high while running |
| send_req_o | output | 1 | Request to send, high while running |

## Verification
The character stream is decoded with clear-to-send held high for more than one full alphabet, which separates a correct increment from a missing or misplaced wrap. Clear-to-send is then dropped between frames and in the middle of frames, directed and at random bit positions with random idle gaps, which tells a gating check made only at frame start apart from one that aborts or delays a frame in progress. Every cycle of every frame is compared against the bit expected at that point, so a wrong divisor or a counter that is not reloaded after idle shows up as a width error rather than as a wrong letter. The ignored inputs toggle at random throughout, and a lowercase instance runs alongside to tell a parameterised base from a hard-coded one.

// File: rtl/alpha_tx_pkg.sv
package alpha_tx_pkg;

    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } phase_e;

    // Stop bit at the top, start bit at the bottom: bit 0 leaves first.
    function automatic logic [FRAME_BITS-1:0] make_frame(input logic [DATA_BITS-1:0] data);
        return {1'b1, data, 1'b0};
    endfunction

endpackage

// File: rtl/alpha_baud_timer.sv
module alpha_baud_timer #(
    parameter int DIV = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_s;

    timer_s cur_q, nxt_d;

    assign tick_o = run_i && (cur_q.cnt == '0);

    always_comb begin
        nxt_d = cur_q;
        if (load_i || tick_o) begin
            nxt_d.cnt = TOP;
        end else if (run_i) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{cnt: TOP};
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R3: a reload always restarts the full period
    assert_full_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cur_q.cnt == TOP);

    // R3: between reloads the counter steps down by one each cycle
    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_i && !load_i && cur_q.cnt != '0 |=> cur_q.cnt == CW'($past(cur_q.cnt) - 1'b1));

endmodule

// File: rtl/alpha_letter_seq.sv
module alpha_letter_seq #(
    parameter logic [7:0] FIRST_CHAR = 8'h41,
    parameter int         ALPHA_LEN  = 26
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance_i,
    output logic [7:0] char_o
);
    localparam int IW = (ALPHA_LEN > 1) ? $clog2(ALPHA_LEN) : 1;
    localparam logic [IW-1:0] LAST = IW'(ALPHA_LEN - 1);

    typedef struct packed {
        logic [IW-1:0] idx;
    } seq_s;

    seq_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (advance_i) begin
            if (cur_q.idx == LAST) begin
                nxt_d.idx = '0;
            end else begin
                nxt_d.idx = cur_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{idx: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign char_o = FIRST_CHAR + 8'(cur_q.idx);

    // R6: the last letter is followed by the base letter
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i && cur_q.idx == LAST |=> char_o == FIRST_CHAR);

    // R5: otherwise each advance moves up by exactly one letter
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i && cur_q.idx != LAST |=> char_o == $past(char_o) + 8'd1);

    // R5: without an advance the letter holds
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(char_o));

endmodule

// File: rtl/alpha_frame_tx.sv
module alpha_frame_tx
    import alpha_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_ok_i,
    input  logic [7:0] char_i,
    input  logic       tick_i,
    output logic       load_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       line_o
);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        phase_e                 phase;
        logic [BIT_IDX_W-1:0]   bit_idx;
        logic [FRAME_BITS-1:0]  shift;
    } frame_s;

    frame_s cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        load_o = 1'b0;
        done_o = 1'b0;
        case (cur_q.phase)
            PH_IDLE: begin
                if (cts_ok_i) begin
                    nxt_d.phase   = PH_SEND;
                    nxt_d.shift   = make_frame(char_i);
                    nxt_d.bit_idx = '0;
                    load_o        = 1'b1;
                end
            end
            PH_SEND: begin
                if (tick_i) begin
                    if (cur_q.bit_idx == LAST_BIT) begin
                        nxt_d.phase = PH_IDLE;
                        nxt_d.shift = '1;
                        done_o      = 1'b1;
                    end else begin
                        nxt_d.shift   = {1'b1, cur_q.shift[FRAME_BITS-1:1]};
                        nxt_d.bit_idx = cur_q.bit_idx + 1'b1;
                    end
                end
            end
            default: nxt_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{phase: PH_IDLE, bit_idx: '0, shift: '1};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy_o = (cur_q.phase == PH_SEND);
    assign line_o = cur_q.shift[0];

    // R2: the line is high whenever no frame is on the wire
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> line_o);

    // R2: a frame begins with a low start bit
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && cts_ok_i |=> busy_o && !line_o);

    // R7: no frame starts while clear-to-send is low
    assert_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && !cts_ok_i |=> !busy_o);

    // R8: a frame in progress keeps going whatever clear-to-send does
    assert_no_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> busy_o);

    // R3: the line only moves on a bit-period tick
    assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !tick_i |=> $stable(line_o));

endmodule

// File: rtl/alpha_uart_dte.sv
module alpha_uart_dte #(
    parameter longint unsigned CLK_HZ     = 12_000_000,
    parameter longint unsigned BAUD       = 9_600,
    parameter logic [7:0]      FIRST_CHAR = 8'h41
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_to_send_i,
    input  logic ser_in_i,
    input  logic carrier_i,
    input  logic peer_ready_i,
    input  logic ring_i,
    output logic ser_out_o,
    output logic term_ready_o,
    output logic send_req_o
);
    localparam int DIV       = int'(CLK_HZ / BAUD);
    localparam int ALPHA_LEN = 26;

    typedef struct packed {
        logic ctl;
    } ctl_s;

    ctl_s ctl_q, ctl_d;

    logic       load;
    logic       busy;
    logic       done;
    logic       tick;
    logic [7:0] cur_char;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ctl = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{ctl: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign term_ready_o = ctl_q.ctl;
    assign send_req_o   = ctl_q.ctl;

    alpha_baud_timer #(
        .DIV (DIV)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .run_i  (busy),
        .tick_o (tick)
    );

    alpha_letter_seq #(
        .FIRST_CHAR (FIRST_CHAR),
        .ALPHA_LEN  (ALPHA_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (done),
        .char_o    (cur_char)
    );

    alpha_frame_tx u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cts_ok_i (clear_to_send_i),
        .char_i   (cur_char),
        .tick_i   (tick),
        .load_o   (load),
        .busy_o   (busy),
        .done_o   (done),
        .line_o   (ser_out_o)
    );

    // R10: control outputs high from the first edge after release onward
    assert_ctl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> term_ready_o && send_req_o);

    // R9: the ignored inputs must still be driven to known levels
    assert_known_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({ser_in_i, carrier_i, peer_ready_i, ring_i}));

    // R4: the letter only changes when a frame completes
    assert_letter_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> $stable(cur_char));

endmodule

// File: tb/sim_alpha_uart_dte.sv
module sim_alpha_uart_dte;

    localparam longint unsigned T_CLK  = 96_000;
    localparam longint unsigned T_BAUD = 9_600;
    localparam int              DIV    = int'(T_CLK / T_BAUD);
    localparam logic [7:0]      UP     = 8'h41;
    localparam logic [7:0]      LOW    = 8'h61;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_a = 1'b1;
    logic       cts_b = 1'b1;
    logic [3:0] noise = 4'h0;
    logic       ser_a, tr_a, rq_a;
    logic       ser_b, tr_b, rq_b;

    int total = 0;
    int bad = 0;
    int ctl_viol = 0;
    int run_cyc = 0;
    int noise_flips = 0;
    int frame_errs = 0;

    always #2.5 clk = ~clk;

    alpha_uart_dte #(.CLK_HZ(T_CLK), .BAUD(T_BAUD), .FIRST_CHAR(UP)) u0 (
        .clk(clk), .rst_n(rst_n), .clear_to_send_i(cts_a),
        .ser_in_i(noise[0]), .carrier_i(noise[1]), .peer_ready_i(noise[2]), .ring_i(noise[3]),
        .ser_out_o(ser_a), .term_ready_o(tr_a), .send_req_o(rq_a));

    alpha_uart_dte #(.CLK_HZ(T_CLK), .BAUD(T_BAUD), .FIRST_CHAR(LOW)) u1 (
        .clk(clk), .rst_n(rst_n), .clear_to_send_i(cts_b),
        .ser_in_i(noise[3]), .carrier_i(noise[2]), .peer_ready_i(noise[1]), .ring_i(noise[0]),
        .ser_out_o(ser_b), .term_ready_o(tr_b), .send_req_o(rq_b));

    function automatic logic [7:0] exp_letter(input logic [7:0] base, input int n);
        return base + 8'(n % 26);
    endfunction

    function automatic logic line_of(input int which);
        return (which == 0) ? ser_a : ser_b;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Receive one frame, comparing every cycle of every bit.
    task automatic recv(input int which, input logic [7:0] exp, input string req, input int drop_bit);
        int   wait_cyc = 0;
        int   width_err = 0;
        logic [9:0] mid;
        logic [9:0] first;
        do begin
            @(negedge clk);
            wait_cyc++;
        end while (line_of(which) === 1'b1 && wait_cyc < 40 * DIV);
        for (int i = 0; i < 10 * DIV; i++) begin
            if (i > 0) @(negedge clk);
            if (drop_bit >= 0 && i == drop_bit * DIV) cts_a = 1'b0;
            if (i % DIV == 0) first[i / DIV] = line_of(which);
            if (i % DIV == DIV / 2) mid[i / DIV] = line_of(which);
            if (i % DIV != 0 && line_of(which) !== first[i / DIV]) width_err++;
        end
        check(mid[0] == 1'b0, "R2", "start bit", int'(mid[0]), 0);
        check(mid[9] == 1'b1, "R2", "stop bit", int'(mid[9]), 1);
        check(width_err == 0, "R3", "cycles off bit value", width_err, 0);
        check(mid[8:1] == exp, req, "character", int'(mid[8:1]), int'(exp));
        if (mid[8:1] != exp || width_err != 0) frame_errs++;
    endtask

    task automatic idle_hold(input int n, input string req);
        int lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ser_a !== 1'b1) lows++;
        end
        check(lows == 0, req, "low cycles while gated", lows, 0);
    endtask

    // Ignored inputs toggle at random on every cycle (R9).
    initial begin
        forever begin
            @(negedge clk);
            noise = 4'($urandom_range(0, 15));
            noise_flips++;
        end
    end

    // Control outputs stay high once running (R10).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (run_cyc > 0 && !(tr_a && rq_a && tr_b && rq_b)) ctl_viol++;
                run_cyc++;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n = 0;
        int rst_bad = 0;
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_A17E);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (ser_a !== 1'b1 || ser_b !== 1'b1 || tr_a !== 1'b0 || rq_a !== 1'b0) rst_bad++;
        end
        check(rst_bad == 0, "R1", "reset-state violations", rst_bad, 0);
        rst_n = 1'b1;

        fork
            begin
                for (int k = 0; k < 28; k++)
                    recv(1, exp_letter(LOW, k), "R11", -1);
            end
            begin
                recv(0, exp_letter(UP, n), "R4", -1);
                n++;
                for (int k = 0; k < 29; k++) begin
                    recv(0, exp_letter(UP, n), (n % 26 == 0) ? "R6" : "R5", -1);
                    n++;
                end
            end
        join
        check(tr_a && rq_a, "R10", "control outputs", int'({tr_a, rq_a}), 3);

        // Directed: gate between frames
        cts_a = 1'b0;
        idle_hold(6 * DIV, "R7");
        cts_a = 1'b1;
        recv(0, exp_letter(UP, n), "R5", -1);
        n++;

        // Directed: drop clear-to-send in the middle of a frame
        recv(0, exp_letter(UP, n), "R8", 4);
        n++;
        idle_hold(3 * DIV, "R7");
        cts_a = 1'b1;
        recv(0, exp_letter(UP, n), "R5", -1);
        n++;

        // Random gaps and mid-frame drops
        for (int it = 0; it < 14; it++) begin
            int gap;
            int drop;
            gap  = $urandom_range(0, 3 * DIV);
            drop = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 9) : -1;
            if (gap > 0) begin
                cts_a = 1'b0;
                idle_hold(gap, "R7");
                cts_a = 1'b1;
            end
            recv(0, exp_letter(UP, n), (drop >= 0) ? "R8" : ((n % 26 == 0) ? "R6" : "R5"), drop);
            n++;
            if (drop >= 0) begin
                idle_hold(2, "R7");
                cts_a = 1'b1;
            end
        end

        check(ctl_viol == 0, "R10", "control drops while running", ctl_viol, 0);
        check(noise_flips > 100 && frame_errs == 0, "R9", "frame errors under input noise", frame_errs, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule